// File: doc/BRIEF.md
# Daylight Saving Time Adjuster

This block sits next to the hours, minutes and seconds counters of a real-time clock. It applies the two yearly daylight-saving corrections when its enable input is high. On the first Sunday of April the clock jumps from 01:59:59 straight to 03:00:00. On the last Sunday of October, the first time 01:59:59 is reached, the clock goes back to 01:00:00 instead of advancing to 02:00:00. The block does not store the counters. It watches their values and, in the cycle of the one-second update strobe, asks the hours counter to load a replacement value.

Whether the current day qualifies is decided once, on the strobe at which the counters read 00:00:00. That decision is held until the next midnight. A one-bit flag records that the autumn correction has fired, so the repeated hour runs normally. The block follows both the BCD and binary data formats and both the 12-hour and 24-hour hour formats. In 12-hour mode, bit 7 of the hours value is the PM flag.

Top module: `dst_adjuster`

## Requirements
- R1: With dst_en high on a day qualified at midnight as a first Sunday of April, a tick while the time reads 01:59:59 AM drives hr_load=1 and hr_value=8'h03 in the same cycle. The day qualifies when month=4, dow=1 (Sunday) and 1 <= date <= 7.
- R2: With dst_en high on a day qualified at midnight as a last Sunday of October (month=10, dow=1, date >= 25), the first tick at 01:59:59 AM drives hr_load=1 and hr_value=8'h01.
- R3: On an October qualifying day, every later tick at 01:59:59 on the same day leaves hr_load at 0.
- R4: Qualification is taken only on the tick at which the time reads 00:00:00, and it is held for the whole day. If dst_en is low at that tick, the day gets no correction even if dst_en is raised later. Date changes during the day do not alter the decision.
- R5: With dst_en low, hr_load stays 0.
- R6: A day that does not meet the April or October condition gets no correction. Examples are April date 8, October date 24, a non-Sunday, or another month.
- R7: bin_mode=1 selects binary values and bin_mode=0 selects BCD. h24_mode=1 selects 24-hour hours and h24_mode=0 selects 12-hour hours. Midnight is hours 8'h00 in 24-hour mode, 8'h12 in 12-hour BCD, and 8'h0C in 12-hour binary. In 12-hour mode, 01:59:59 PM (hours 8'h81) triggers nothing.
- R8: An active-low reset clears the held qualification and the fall-back flag. dst_en is an input and is not altered by reset.
- R9: hr_load is high only in a cycle where tick is high.
- R10: The fall-back flag clears at the next midnight tick, so a newly qualifying day can be corrected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second update strobe, one cycle wide |
| dst_en | input | 1 | Daylight-saving enable |
| bin_mode | input | 1 | 1 = binary values, 0 = BCD values |
| h24_mode | input | 1 | 1 = 24-hour hours, 0 = 12-hour hours with PM at bit 7 |
| month | input | 8 | Current month |
| date | input | 8 | Current day of month |
| dow | input | 3 | Day of week, 1 = Sunday |
| hours | input | 8 | Current hours counter value |
| minutes | input | 8 | Current minutes counter value |
| seconds | input | 8 | Current seconds counter value |
| hr_load | output | 1 | Load request for the hours counter, same cycle as tick |
| hr_value | output | 8 | Value to load into the hours counter |

## Verification
The assertions assume that tick is a single-cycle pulse and that the counter inputs hold valid values in the selected format during a strobe. Under that assumption, matching 01:59:59 alone identifies the moment of correction. The bench drives the counters only with legal encodings for the mode in force. It presents each time value for one strobe and changes inputs only at falling clock edges. For every vector, the bench first applies a midnight strobe with the intended enable and then applies a strobe at 01:59:59.

// File: rtl/dst_adjuster.sv
module dst_adjuster (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       dst_en,
  input  logic       bin_mode,
  input  logic       h24_mode,
  input  logic [7:0] month,
  input  logic [7:0] date,
  input  logic [2:0] dow,
  input  logic [7:0] hours,
  input  logic [7:0] minutes,
  input  logic [7:0] seconds,
  output logic       hr_load,
  output logic [7:0] hr_value
);
  localparam logic [7:0] HR_ONE   = 8'h01;
  localparam logic [7:0] HR_THREE = 8'h03;
  localparam logic [7:0] APRIL    = 8'h04;
  localparam logic [2:0] SUNDAY   = 3'd1;

  logic spring_day, fall_day, fall_done;

  wire [7:0] mid_hr  = h24_mode ? 8'h00 : (bin_mode ? 8'h0C : 8'h12);
  wire [7:0] last_ms = bin_mode ? 8'd59 : 8'h59;
  wire [7:0] oct_val = bin_mode ? 8'd10 : 8'h10;
  wire [7:0] d25_val = bin_mode ? 8'd25 : 8'h25;

  wire is_sun     = dow == SUNDAY;
  wire at_midnt   = hours == mid_hr && minutes == 8'h00 && seconds == 8'h00;
  wire at_0159    = hours == HR_ONE && minutes == last_ms && seconds == last_ms;
  wire day_tick   = tick && at_midnt;
  wire spring_hit = tick && dst_en && spring_day && at_0159;
  wire fall_hit   = tick && dst_en && fall_day && !fall_done && at_0159;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spring_day <= 1'b0;
      fall_day   <= 1'b0;
      fall_done  <= 1'b0;
    end else if (day_tick) begin
      spring_day <= dst_en && is_sun && month == APRIL && date != 8'h00 && date <= 8'h07;
      fall_day   <= dst_en && is_sun && month == oct_val && date >= d25_val;
      fall_done  <= 1'b0;
    end else if (fall_hit) begin
      fall_done  <= 1'b1;
    end
  end

  assign hr_load  = spring_hit || fall_hit;
  assign hr_value = spring_hit ? HR_THREE : (fall_hit ? HR_ONE : 8'h00);

  p_load_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hr_load |-> tick);
  p_off_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_en |-> !hr_load);
  p_fall_marks_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_load && hr_value == HR_ONE) |=> fall_done);
  p_no_second_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_done |-> !(hr_load && hr_value == HR_ONE));
  p_done_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_done && !day_tick) |=> fall_done);
  p_load_at_0159_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hr_load |-> (hours == HR_ONE && minutes == last_ms && seconds == last_ms));
endmodule

// File: tb/sim_dst_adjuster.sv
module sim_dst_adjuster;
  logic clk = 1'b0;
  logic rst_n = 1'b0, tick = 1'b0, dst_en = 1'b0, bin_mode = 1'b0, h24_mode = 1'b1;
  logic [7:0] month = 8'h01, date = 8'h01, hours = 8'h00, minutes = 8'h00, seconds = 8'h00;
  logic [2:0] dow = 3'd2;
  logic hr_load;
  logic [7:0] hr_value;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dst_adjuster u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .dst_en(dst_en),
    .bin_mode(bin_mode), .h24_mode(h24_mode), .month(month), .date(date), .dow(dow),
    .hours(hours), .minutes(minutes), .seconds(seconds), .hr_load(hr_load), .hr_value(hr_value));

  // {bin, h24, month, date, dow, en, exp_load, exp_value}
  localparam int NV = 10;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h04, 8'h05, 3'd1, 1'b1, 1'b1, 8'h03},
    {1'b1, 1'b0, 8'h04, 8'h07, 3'd1, 1'b1, 1'b1, 8'h03},
    {1'b0, 1'b0, 8'h04, 8'h08, 3'd1, 1'b1, 1'b0, 8'h00},
    {1'b0, 1'b1, 8'h10, 8'h25, 3'd1, 1'b1, 1'b1, 8'h01},
    {1'b1, 1'b1, 8'h0A, 8'h1F, 3'd1, 1'b1, 1'b1, 8'h01},
    {1'b1, 1'b0, 8'h0A, 8'h18, 3'd1, 1'b1, 1'b0, 8'h00},
    {1'b0, 1'b1, 8'h04, 8'h03, 3'd2, 1'b1, 1'b0, 8'h00},
    {1'b0, 1'b1, 8'h04, 8'h03, 3'd1, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b0, 8'h10, 8'h31, 3'd1, 1'b1, 1'b1, 8'h01},
    {1'b0, 1'b1, 8'h03, 8'h01, 3'd1, 1'b1, 1'b0, 8'h00}
  };

  function automatic logic [7:0] mid_enc();
    return h24_mode ? 8'h00 : (bin_mode ? 8'h0C : 8'h12);
  endfunction

  function automatic logic [7:0] m59();
    return bin_mode ? 8'd59 : 8'h59;
  endfunction

  task automatic check(input logic [8:0] act, input logic [8:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s load/value actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    @(negedge clk);
    hours = h; minutes = m; seconds = s; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic midnight();
    strobe(mid_enc(), 8'h00, 8'h00);
  endtask

  task automatic probe_0159(input logic [8:0] exp, input string req);
    @(negedge clk);
    hours = 8'h01; minutes = m59(); seconds = m59(); tick = 1'b1;
    #1 check({hr_load, hr_value}, exp, req);
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check({hr_load, hr_value}, 9'h000, "R8 reset state");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      bin_mode = v[30]; h24_mode = v[29]; month = v[28:21]; date = v[20:13];
      dow = v[12:10]; dst_en = v[9];
      midnight();
      probe_0159(v[8:0], "R1/R2/R6/R7 vector");
      if (v[8] && v[7:0] == 8'h01) begin
        strobe(8'h01, 8'h00, 8'h00);
        probe_0159(9'h000, "R3 repeated hour");
      end
    end

    // R5: enable low at 01:59:59 on a qualified day
    bin_mode = 0; h24_mode = 1; month = 8'h04; date = 8'h02; dow = 1; dst_en = 1;
    midnight();
    dst_en = 0;
    probe_0159(9'h000, "R5 enable off");

    // R4: enable low at midnight, raised later
    dst_en = 0; midnight(); dst_en = 1;
    probe_0159(9'h000, "R4 enable late");

    // R4: decision held despite date change
    dst_en = 1; midnight(); date = 8'h10; dow = 3'd3;
    probe_0159(9'h103, "R4 latched decision");

    // R9: 01:59:59 without tick
    date = 8'h02; dow = 1; midnight();
    @(negedge clk);
    hours = 8'h01; minutes = 8'h59; seconds = 8'h59; tick = 1'b0;
    #1 check({hr_load, hr_value}, 9'h000, "R9 no tick");
    probe_0159(9'h103, "R9 with tick");

    // R7: PM in 12-hour mode
    h24_mode = 0; midnight();
    @(negedge clk);
    hours = 8'h81; minutes = 8'h59; seconds = 8'h59; tick = 1'b1;
    #1 check({hr_load, hr_value}, 9'h000, "R7 PM ignored");
    @(negedge clk); tick = 1'b0;

    // R8: reset clears held qualification
    h24_mode = 1; midnight();
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    probe_0159(9'h000, "R8 reset clears");

    // R10: fall-back flag re-armed at next midnight
    month = 8'h10; date = 8'h26;
    midnight();
    probe_0159(9'h101, "R10 first fall");
    probe_0159(9'h000, "R3 blocked");
    midnight();
    probe_0159(9'h101, "R10 re-armed");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule